// File: doc/BRIEF.md
# Switching-Cycle Generator with Jitter, Foldback and Burst Skip

This block paces the power switch of a fixed-frequency current-mode flyback controller. A phase accumulator advances by an increment every clock cycle. Each wrap of the accumulator opens a new switching cycle. On that wrap the gate-drive enable goes high and a one-cycle start strobe is issued. The pulse ends at the first of two events: the analog current-limit flag rises, or the phase reaches the maximum-duty point of the cycle.

The increment has two parts. The first is a base value taken from the digitized feedback level. It holds the nominal rate at high feedback, falls linearly between two thresholds, and rests at a floor of about 28/65 of nominal at low feedback. The second is a signed triangular jitter term that spreads the spectrum and stays active at every feedback level. A parameter picks either the 65 kHz or the 100 kHz base rate.

At very low feedback the block enters burst skip and starts no new pulses. It waits for any pulse in progress to end normally before it stops. It leaves skip only when feedback climbs past a higher exit level. Every burst contains a minimum number of pulses before skip can be entered again.

Top module: `swcyc_gen`

## Requirements
- R1: With `fb_code` at or above FOLD_START, pulses start at accumulator wraps spaced 2^ACC_W / increment cycles apart. The base increment is INC_NOM_LO, or INC_NOM_HI when HI_FREQ=1. Each start raises `cyc_start` for exactly one cycle, in the same cycle that `drv_en` rises.
- R2: When `ilim` stays low, `drv_en` falls on the first clock edge at which the accumulator reaches DMAX_PCT percent of full scale (default 80). The on-time therefore never exceeds that share of the cycle.
- R3: If `ilim` is high in a cycle where `drv_en` is high, `drv_en` is low in the following cycle.
- R4: The jitter term is a symmetric triangle between -JIT_AMP and +JIT_AMP. It starts at 0 after reset, rises first, and moves by exactly one increment unit every JIT_DIV cycles.
- R5: For `fb_code` strictly between FOLD_END and FOLD_START, the base increment is INC_MIN + (fb_code-FOLD_END)*(NOM-INC_MIN)/(FOLD_START-FOLD_END), using integer division. At or below FOLD_END the base increment is INC_MIN.
- R6: Jitter and the maximum-duty cut-off both remain in force while the frequency is folded back.
- R7: When `fb_code` is at or below SKIP_IN, no new pulse starts. Skip begins only once `drv_en` is low, so a pulse in progress is never shortened.
- R8: Skip is left only when `fb_code` is strictly greater than SKIP_OUT, where SKIP_OUT > SKIP_IN. Levels between the two, including SKIP_OUT itself, keep the block in skip.
- R9: After skip is left, at least MIN_BURST pulses (default 3) start before skip can be entered again.
- R10: During reset `drv_en` and `cyc_start` are low. The accumulator and the jitter term both start at zero, so the first pulse follows about 2^ACC_W / NOM cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_code | input | FB_W | Digitized feedback level |
| ilim | input | 1 | Peak current reached; ends the present pulse |
| drv_en | output | 1 | Gate-drive enable |
| cyc_start | output | 1 | One-cycle strobe at each pulse start |

## Verification
A corrupted accumulator or increment shows up at once in the spacing of `cyc_start` strobes. The spacing would fall outside the floor/ceiling window that the bench derives from feedback and jitter amplitude, within one or two switching periods. A frozen or runaway jitter state shows as a period spread that is too narrow or too wide across one triangle sweep. A wrong skip state or burst count shows within a few hundred cycles in one of three ways: strobes appear while feedback sits inside the hysteresis band, strobes are missing after the exit level is crossed, or a burst does not hold exactly the minimum number of pulses. A pulse cut short by skip entry shows as an on-time below the floor computed for that increment.

// File: rtl/swcyc_pkg.sv
package swcyc_pkg;
   typedef enum logic {ST_RUN = 1'b0, ST_SKIP = 1'b1} skip_st_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction
endpackage

// File: rtl/swcyc_jitter.sv
module swcyc_jitter #(
   parameter int JIT_W   = 7,
   parameter int JIT_AMP = 63,
   parameter int JIT_DIV = 132,
   parameter int JIT_EN  = 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   output logic signed [JIT_W-1:0] jit_o
);
   localparam int DIV_W = (JIT_DIV > 1) ? $clog2(JIT_DIV) : 1;

   generate
      if (JIT_EN != 0 && JIT_AMP > 0) begin : g_tri
         logic [DIV_W-1:0]        dcnt;
         logic                    up;
         logic signed [JIT_W-1:0] jq;
         logic                    tick;

         assign tick  = (dcnt == DIV_W'(JIT_DIV - 1));
         assign jit_o = jq;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dcnt <= '0;
               up   <= 1'b1;
               jq   <= '0;
            end else begin
               dcnt <= tick ? '0 : dcnt + DIV_W'(1);
               if (tick) begin
                  if (up) begin
                     if (jq == JIT_W'(JIT_AMP)) begin
                        up <= 1'b0;
                        jq <= jq - JIT_W'(1);
                     end else begin
                        jq <= jq + JIT_W'(1);
                     end
                  end else begin
                     if (jq == JIT_W'(-JIT_AMP)) begin
                        up <= 1'b1;
                        jq <= jq + JIT_W'(1);
                     end else begin
                        jq <= jq - JIT_W'(1);
                     end
                  end
               end
            end
         end

         // R4: the triangle never leaves its band
         a_r4_jit_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(jq) <= JIT_AMP) && (int'(jq) >= -JIT_AMP));
         // R4: the term only ever moves by a single unit
         a_r4_jit_step: assert property (@(posedge clk) disable iff (!rst_n)
            (jq != $past(jq)) |-> ((int'(jq) - int'($past(jq)) == 1) ||
                                   (int'(jq) - int'($past(jq)) == -1)));
      end else begin : g_flat
         assign jit_o = '0;
      end
   endgenerate
endmodule

// File: rtl/swcyc_fold.sv
module swcyc_fold #(
   parameter int FB_W       = 8,
   parameter int INC_W      = 16,
   parameter int INC_NOM    = 1024,
   parameter int INC_MIN    = 441,
   parameter int FOLD_START = 160,
   parameter int FOLD_END   = 96,
   parameter int JIT_W      = 7
) (
   input  logic [FB_W-1:0]         fb_i,
   input  logic signed [JIT_W-1:0] jit_i,
   output logic [INC_W-1:0]        inc_o
);
   localparam int SPAN   = FOLD_START - FOLD_END;
   localparam int DELTA  = INC_NOM - INC_MIN;
   localparam int PROD_W = FB_W + INC_W;

   logic [FB_W-1:0]         fb_off;
   logic [PROD_W-1:0]       prod;
   logic [PROD_W-1:0]       quot;
   logic [INC_W-1:0]        base;
   logic signed [INC_W:0]   sum;

   always_comb begin
      fb_off = fb_i - FB_W'(FOLD_END);
      prod   = PROD_W'(fb_off) * PROD_W'(DELTA);
      quot   = prod / PROD_W'(SPAN);
      if (fb_i >= FB_W'(FOLD_START))
         base = INC_W'(INC_NOM);
      else if (fb_i <= FB_W'(FOLD_END))
         base = INC_W'(INC_MIN);
      else
         base = INC_W'(INC_MIN) + quot[INC_W-1:0];
      sum   = $signed({1'b0, base}) + (INC_W+1)'(jit_i);
      inc_o = sum[INC_W-1:0];
   end
endmodule

// File: rtl/swcyc_drive.sv
module swcyc_drive #(
   parameter int ACC_W      = 16,
   parameter int DMAX_PH    = 52428,
   parameter int MAX_ON_CYC = 90
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] inc_i,
   input  logic             ilim_i,
   input  logic             start_ok_i,
   output logic             drv_o,
   output logic             strobe_o
);
   localparam int OC_W = $clog2(MAX_ON_CYC + 2) + 1;

   logic [ACC_W-1:0] acc;
   logic [ACC_W-1:0] acc_nx;
   logic             carry;
   logic             at_max;

   assign {carry, acc_nx} = {1'b0, acc} + {1'b0, inc_i};
   assign at_max          = (acc_nx >= ACC_W'(DMAX_PH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         drv_o    <= 1'b0;
         strobe_o <= 1'b0;
      end else begin
         acc      <= acc_nx;
         strobe_o <= 1'b0;
         if (carry && start_ok_i) begin
            drv_o    <= 1'b1;
            strobe_o <= 1'b1;
         end else if (drv_o && (ilim_i || at_max)) begin
            drv_o <= 1'b0;
         end
      end
   end

   logic [OC_W-1:0] on_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         on_cnt <= '0;
      else if (!drv_o)
         on_cnt <= '0;
      else if (on_cnt != '1)
         on_cnt <= on_cnt + OC_W'(1);
   end

   // R2: on-time bounded by maximum duty at the slowest increment
   a_r2_on_limit: assert property (@(posedge clk) disable iff (!rst_n)
      drv_o |-> (on_cnt <= OC_W'(MAX_ON_CYC)));
   // R1: strobe is a single-cycle pulse that coincides with drive high
   a_r1_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);
   a_r1_strobe_drv: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |-> drv_o);
   // R3: current limit ends the pulse one cycle later
   a_r3_ilim_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_o && ilim_i) |=> (!drv_o || strobe_o));
endmodule

// File: rtl/swcyc_skip.sv
module swcyc_skip
   import swcyc_pkg::*;
#(
   parameter int FB_W      = 8,
   parameter int SKIP_IN   = 48,
   parameter int SKIP_OUT  = 64,
   parameter int MIN_BURST = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FB_W-1:0] fb_i,
   input  logic            drv_i,
   input  logic            strobe_i,
   output logic            start_ok_o
);
   localparam int BC_W = $clog2(MIN_BURST + 1);

   skip_st_t        st;
   logic [BC_W-1:0] bcnt;
   logic            enter;
   logic            leave;

   assign enter = (st == ST_RUN) && (fb_i <= FB_W'(SKIP_IN)) &&
                  (bcnt >= BC_W'(MIN_BURST)) && !drv_i;
   assign leave = (st == ST_SKIP) && (fb_i > FB_W'(SKIP_OUT));
   assign start_ok_o = (st == ST_RUN) && !enter;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_RUN;
         bcnt <= '0;
      end else if (st == ST_RUN) begin
         if (enter)
            st <= ST_SKIP;
         else if (strobe_i && (bcnt < BC_W'(MIN_BURST)))
            bcnt <= bcnt + BC_W'(1);
      end else if (leave) begin
         st   <= ST_RUN;
         bcnt <= '0;
      end
   end

   // R7: no pulse is started while skipping
   a_r7_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> !strobe_i);
   // R7: skip is only entered with the driver idle
   a_r7_enter_idle: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st == ST_SKIP) |-> !drv_i);
   // R9: skipping implies a complete minimum burst
   a_r9_burst_min: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> (bcnt >= BC_W'(MIN_BURST)));
   // R8: leaving skip needs feedback above the exit level
   a_r8_exit_level: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st == ST_SKIP) |-> ($past(fb_i) > FB_W'(SKIP_OUT)));
endmodule

// File: rtl/swcyc_gen.sv
module swcyc_gen
   import swcyc_pkg::*;
#(
   parameter int ACC_W      = 16,
   parameter int FB_W       = 8,
   parameter int HI_FREQ    = 0,
   parameter int INC_NOM_LO = 1024,
   parameter int INC_NOM_HI = 1575,
   parameter int INC_MIN    = 441,
   parameter int JIT_AMP    = 63,
   parameter int JIT_DIV    = 132,
   parameter int JIT_EN     = 1,
   parameter int DMAX_PCT   = 80,
   parameter int FOLD_START = 160,
   parameter int FOLD_END   = 96,
   parameter int SKIP_OUT   = 64,
   parameter int SKIP_IN    = 48,
   parameter int MIN_BURST  = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [FB_W-1:0] fb_code,
   input  logic            ilim,
   output logic            drv_en,
   output logic            cyc_start
);
   localparam int INC_NOM    = (HI_FREQ != 0) ? INC_NOM_HI : INC_NOM_LO;
   localparam int FULL       = 2 ** ACC_W;
   localparam int DMAX_PH    = (FULL * DMAX_PCT) / 100;
   localparam int JIT_W      = $clog2(JIT_AMP + 1) + 1;
   localparam int MAX_ON_CYC = ceil_div(DMAX_PH, INC_MIN - JIT_AMP) + 1;

   generate
      if (ACC_W < 4 || ACC_W > 24) begin : g_bad_acc
         $error("ACC_W out of range");
      end
      if (INC_NOM + JIT_AMP >= FULL / 2) begin : g_bad_nom
         $error("nominal increment too large for the accumulator");
      end
      if (JIT_AMP >= INC_MIN || INC_MIN >= INC_NOM) begin : g_bad_min
         $error("increment floor must exceed jitter and stay below nominal");
      end
      if (FOLD_START <= FOLD_END || FOLD_START >= 2 ** FB_W) begin : g_bad_fold
         $error("foldback thresholds inconsistent");
      end
      if (SKIP_OUT <= SKIP_IN || SKIP_OUT > FOLD_END) begin : g_bad_skip
         $error("skip thresholds inconsistent");
      end
      if (DMAX_PCT < 1 || DMAX_PCT > 99 || MIN_BURST < 1 || JIT_DIV < 1) begin : g_bad_misc
         $error("duty, burst or jitter divider out of range");
      end
   endgenerate

   logic signed [JIT_W-1:0] jit;
   logic [ACC_W-1:0]        inc;
   logic                    start_ok;

   swcyc_jitter #(
      .JIT_W(JIT_W), .JIT_AMP(JIT_AMP), .JIT_DIV(JIT_DIV), .JIT_EN(JIT_EN)
   ) u_jit (
      .clk(clk), .rst_n(rst_n), .jit_o(jit)
   );

   swcyc_fold #(
      .FB_W(FB_W), .INC_W(ACC_W), .INC_NOM(INC_NOM), .INC_MIN(INC_MIN),
      .FOLD_START(FOLD_START), .FOLD_END(FOLD_END), .JIT_W(JIT_W)
   ) u_fold (
      .fb_i(fb_code), .jit_i(jit), .inc_o(inc)
   );

   swcyc_drive #(
      .ACC_W(ACC_W), .DMAX_PH(DMAX_PH), .MAX_ON_CYC(MAX_ON_CYC)
   ) u_drv (
      .clk(clk), .rst_n(rst_n), .inc_i(inc), .ilim_i(ilim),
      .start_ok_i(start_ok), .drv_o(drv_en), .strobe_o(cyc_start)
   );

   swcyc_skip #(
      .FB_W(FB_W), .SKIP_IN(SKIP_IN), .SKIP_OUT(SKIP_OUT), .MIN_BURST(MIN_BURST)
   ) u_skip (
      .clk(clk), .rst_n(rst_n), .fb_i(fb_code), .drv_i(drv_en),
      .strobe_i(cyc_start), .start_ok_o(start_ok)
   );

   // R5/R6: the increment stays inside the folded, jittered band
   a_r5_inc_band: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(inc) >= INC_MIN - JIT_AMP) && (int'(inc) <= INC_NOM + JIT_AMP));
endmodule

// File: tb/sim_swcyc_gen.sv
module sim_swcyc_gen;
   localparam int CLK_PERIOD = 10;
   localparam int ACC_W = 12;
   localparam int FULL  = 2 ** ACC_W;
   localparam int NOM   = 256;
   localparam int MINC  = 110;
   localparam int AMP   = 16;
   localparam int FS    = 160;
   localparam int FE    = 96;
   localparam int SOUT  = 64;
   localparam int SIN   = 48;
   localparam int DMAXP = (FULL * 80) / 100;
   localparam int WD_LIMIT = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] fb = 8'd200;
   logic       ilim = 1'b0;
   logic       drv_en;
   logic       cyc_start;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done = 1'b0;

   int m_nstr, m_minp, m_maxp, m_minon, m_maxon;

   always #(CLK_PERIOD / 2) clk = ~clk;

   swcyc_gen #(
      .ACC_W(ACC_W), .FB_W(8), .HI_FREQ(0), .INC_NOM_LO(NOM), .INC_NOM_HI(394),
      .INC_MIN(MINC), .JIT_AMP(AMP), .JIT_DIV(4), .JIT_EN(1), .DMAX_PCT(80),
      .FOLD_START(FS), .FOLD_END(FE), .SKIP_OUT(SOUT), .SKIP_IN(SIN), .MIN_BURST(3)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .fb_code(fb), .ilim(ilim),
      .drv_en(drv_en), .cyc_start(cyc_start)
   );

   function automatic int exp_base(input int f);
      if (f >= FS) return NOM;
      if (f <= FE) return MINC;
      return MINC + ((f - FE) * (NOM - MINC)) / (FS - FE);
   endfunction
   function automatic int pmin(input int b); return FULL / (b + AMP); endfunction
   function automatic int pmax(input int b); return (FULL + b - AMP - 1) / (b - AMP); endfunction
   function automatic int onmin(input int b); return DMAXP / (b + AMP); endfunction
   function automatic int onmax(input int b); return (DMAXP + b - AMP - 1) / (b - AMP); endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic measure(input int n);
      int last, on;
      bit ign;
      m_nstr = 0; m_minp = 1000000; m_maxp = 0; m_minon = 1000000; m_maxon = 0;
      last = -1; on = 0; ign = drv_en;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (cyc_start) begin
            m_nstr++;
            if (last >= 0) begin
               if (i - last < m_minp) m_minp = i - last;
               if (i - last > m_maxp) m_maxp = i - last;
            end
            last = i;
         end
         if (drv_en) on++;
         else begin
            if (on > 0 && !ign) begin
               if (on < m_minon) m_minon = on;
               if (on > m_maxon) m_maxon = on;
            end
            on = 0;
            ign = 1'b0;
         end
      end
   endtask

   task automatic check_level(input int f, input string tag);
      int b;
      b = exp_base(f);
      chk(m_minp >= pmin(b), {tag, " period floor"}, m_minp, pmin(b));
      chk(m_maxp <= pmax(b), {tag, " period ceiling"}, m_maxp, pmax(b));
      chk(m_minon >= onmin(b), "R2 on-time floor", m_minon, onmin(b));
      chk(m_maxon <= onmax(b), "R2 on-time ceiling", m_maxon, onmax(b));
   endtask

   task automatic burst(input int hold);
      int n;
      n = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (i == 0) fb = 8'd255;
         if (i == hold) fb = 8'd0;
         if (cyc_start) n++;
      end
      chk(n == 3, "R9 burst length", n, 3);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WD_LIMIT && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, WD_LIMIT);
         finish_run();
      end
   end

   initial begin
      int first, on, f;
      void'($urandom(32'd20240611));
      // R10: reset state
      idle(5);
      chk(drv_en == 1'b0, "R10 drv in reset", int'(drv_en), 0);
      chk(cyc_start == 1'b0, "R10 strobe in reset", int'(cyc_start), 0);
      rst_n = 1'b1;
      first = 0;
      for (int i = 1; i <= 40; i++) begin
         @(negedge clk);
         if (cyc_start && first == 0) first = i;
      end
      chk(first >= 14 && first <= 17, "R10 first pulse delay", first, 16);

      // R1 / R4 / R2 at nominal feedback
      fb = 8'd200;
      idle(60);
      measure(600);
      check_level(200, "R1");
      chk(m_minp <= 15, "R4 jitter fast side", m_minp, 15);
      chk(m_maxp >= 17, "R4 jitter slow side", m_maxp, 17);

      // R5 / R6 inside foldback
      fb = 8'd128;
      idle(60);
      measure(600);
      check_level(128, "R5");
      chk(m_maxp - m_minp >= 2, "R6 jitter in foldback", m_maxp - m_minp, 2);

      // R5 / R6 at the frequency floor
      fb = 8'd80;
      idle(100);
      measure(800);
      check_level(80, "R5 floor");

      // random levels above the skip exit
      for (int k = 0; k < 6; k++) begin
         f = int'($urandom_range(255, SOUT + 1));
         fb = 8'(f);
         idle(100);
         measure(600);
         check_level(f, "R1 R5 random");
      end

      // R3: current limit ends the pulse on the next cycle
      fb = 8'd200;
      idle(60);
      do @(negedge clk); while (!cyc_start);
      @(negedge clk);
      ilim = 1'b1;
      @(negedge clk);
      chk(drv_en == 1'b0, "R3 ilim cut", int'(drv_en), 0);
      ilim = 1'b0;

      // R7: skip entry mid-pulse does not truncate it
      idle(40);
      do @(negedge clk); while (!cyc_start);
      fb = 8'd0;
      on = 1;
      forever begin
         @(negedge clk);
         if (drv_en) on++;
         else break;
      end
      chk(on >= onmin(NOM), "R7 no truncated pulse", on, onmin(NOM));
      measure(300);
      chk(m_nstr == 0, "R7 no pulses in skip", m_nstr, 0);

      // R8: hysteresis band
      fb = 8'd56;
      measure(300);
      chk(m_nstr == 0, "R8 band holds skip", m_nstr, 0);
      fb = 8'(SOUT);
      measure(300);
      chk(m_nstr == 0, "R8 exit level itself holds skip", m_nstr, 0);
      fb = 8'(SOUT + 1);
      measure(300);
      chk(m_nstr > 0, "R8 leave above exit level", m_nstr, 1);

      // R9: minimum burst
      fb = 8'd0;
      idle(200);
      measure(100);
      chk(m_nstr == 0, "R9 skip before burst", m_nstr, 0);
      burst(1);
      burst(20);

      finish_run();
   end
endmodule